// File: doc/BRIEF.md
# Per-Core Event Counter Accumulation Engine

This block sits beside a processor core and keeps four 64-bit event counters running without software ever reading them. Counter 0 counts core clock cycles and counter 1 counts retired instructions. Counters 2 and 3 each pick one line from their own 128-wide event vector. Once collection is started, a sample timer expires every programmed number of cycles. On each expiry the block walks the four counters in turn. For each one it reads the matching 64-bit word of an accumulation record in main memory, adds the live count, writes the sum back and zeroes the live counter. The record sits at the core base address plus the thread offset, and counter k occupies byte offset 8*k.

Software controls the block through a write-only configuration port and three command pulses. The configuration port holds the two event selects, the sample period, the core base address and the thread offset. The commands are init, start and stop. The block has no interrupt output. Its sequencer has five states: IDLE (collection off), WAIT (timer counting down), READ (read request issued), READ_WAIT (waiting for read data) and WRITE (sum written, live counter cleared). The transitions are:
- IDLE to WAIT on start when the period is non-zero.
- WAIT to READ on timer expiry, beginning at counter 0.
- READ to READ_WAIT unconditionally.
- READ_WAIT to WRITE when read data arrives.
- WRITE to READ for the next counter.
- WRITE after counter 3 back to WAIT, or to IDLE if the period is now zero.
- Any state to IDLE on init or stop.

Top module: `cpmc_accum_engine`

## Requirements
- R1: Record word 0 accumulates the number of clock edges at which `cyc_tick` was high while collecting. Record word 1 does the same for `inst_tick`.
- R2: Counter 2 counts edges at which `evt_a_vec[sel_a]` is high, and counter 3 counts edges at which `evt_b_vec[sel_b]` is high. The 7-bit selects are written at configuration address 0 (sel_a) and address 1 (sel_b). All other vector bits have no effect.
- R3: Configuration address 2 holds the period P. The first read of a sample is issued in the cycle that begins P edges after the edge that accepts start. Each following sample's first read comes P+1 edges after the edge that completes the previous sample's last write.
- R4: A sample issues eight requests in this order: a read then a write for counter 0, then the same for counters 1, 2 and 3. Both requests for counter k use address base (config address 3) + offset (config address 4) + 8*k. Each write carries the value read plus the live count, summed over the full 64 bits.
- R5: The live counter is cleared when its word is written, and an event in that same cycle is kept. Totals across many back-to-back samples are therefore exact, with no event lost or counted twice.
- R6: With a period of zero, start is ignored and no memory request is made.
- R7: From the cycle after a stop, no memory request is made. Events that arrive while collection is off are not counted.
- R8: Init clears all live counters and the sample timer, and leaves the block idle.
- R9: A select written while collecting takes effect only from the next sample period.
- R10: After reset no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index (0 sel_a, 1 sel_b, 2 period, 3 base, 4 offset) |
| cfg_wdata | input | 64 | Configuration write data |
| cmd_init | input | 1 | Clear counters and timer, go idle |
| cmd_start | input | 1 | Begin collection |
| cmd_stop | input | 1 | End collection |
| cyc_tick | input | 1 | Core cycle event |
| inst_tick | input | 1 | Instruction retired event |
| evt_a_vec | input | 128 | Event vector for counter 2 |
| evt_b_vec | input | 128 | Event vector for counter 3 |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 64 | Byte address of the 64-bit word |
| mem_wdata | output | 64 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |

## Verification
An event driven in one cycle is counted at the next edge. A start pulse yields the first read request P edges later, and read data that returns one edge after the request lets the matching write go out two edges after the read. The bench drives every input on the falling edge and samples outputs there too. It counts falling edges from start to find the exact cycle of the first read, and it checks the spacing between samples from the edge numbers its memory model records. Record contents are compared only after all events have stopped and a full period plus transfer margin (2P+60 cycles) has passed, so the last sample has finished before the words are read.

// File: rtl/cpmc_pkg.sv
package cpmc_pkg;
    localparam int NUM_CTR   = 4;
    localparam int NUM_FIXED = 2;
    localparam int NUM_SEL   = NUM_CTR - NUM_FIXED;
    localparam int EVT_N     = 128;
    localparam int SEL_W     = $clog2(EVT_N);
    localparam int IDX_W     = $clog2(NUM_CTR);
    localparam int CFG_AW    = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RD,
        ST_RWAIT,
        ST_WR
    } seq_state_e;

    typedef enum logic [CFG_AW-1:0] {
        REG_SEL_A  = 3'd0,
        REG_SEL_B  = 3'd1,
        REG_PERIOD = 3'd2,
        REG_BASE   = 3'd3,
        REG_OFFS   = 3'd4
    } cfg_reg_e;
endpackage

// File: rtl/cpmc_cfg_regs.sv
module cpmc_cfg_regs
    import cpmc_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int PER_W  = 32,
    parameter int CFG_DW = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [CFG_AW-1:0]              wr_addr,
    input  logic [CFG_DW-1:0]              wr_data,
    input  logic                           relatch,
    output logic [NUM_SEL-1:0][SEL_W-1:0]  sel_act,
    output logic [PER_W-1:0]               period,
    output logic [ADDR_W-1:0]              core_base,
    output logic [ADDR_W-1:0]              thread_off
);
    logic [NUM_SEL-1:0][SEL_W-1:0] sel_stage;

    // Staged selects are written by software; active copies follow only at period boundaries.
    for (genvar j = 0; j < NUM_SEL; j++) begin : g_sel
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_stage[j] <= '0;
                sel_act[j]   <= '0;
            end else begin
                if (wr_en && (wr_addr == CFG_AW'(int'(REG_SEL_A) + j)))
                    sel_stage[j] <= wr_data[SEL_W-1:0];
                if (relatch)
                    sel_act[j] <= sel_stage[j];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period     <= '0;
            core_base  <= '0;
            thread_off <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                REG_PERIOD: period     <= wr_data[PER_W-1:0];
                REG_BASE:   core_base  <= wr_data[ADDR_W-1:0];
                REG_OFFS:   thread_off <= wr_data[ADDR_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cpmc_sample_timer.sv
module cpmc_sample_timer #(
    parameter int PER_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [PER_W-1:0] load_val,
    input  logic             run,
    output logic             expire
);
    logic [PER_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (clear)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (run && remain != '0)
            remain <= remain - PER_W'(1);
    end

    assign expire = run && (remain == PER_W'(1));
endmodule

// File: rtl/cpmc_counter_bank.sv
module cpmc_counter_bank
    import cpmc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear_all,
    input  logic                           count_en,
    input  logic                           cyc_tick,
    input  logic                           inst_tick,
    input  logic [NUM_SEL-1:0][EVT_N-1:0]  evt_vec,
    input  logic [NUM_SEL-1:0][SEL_W-1:0]  sel,
    input  logic [NUM_CTR-1:0]             flush,
    output logic [NUM_CTR-1:0][CNT_W-1:0]  count
);
    logic [NUM_FIXED-1:0] fixed_evt;
    logic [NUM_CTR-1:0]   hit;

    assign fixed_evt = {inst_tick, cyc_tick};

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
        if (k < NUM_FIXED) begin : g_fixed
            assign hit[k] = fixed_evt[k];
        end else begin : g_selectable
            assign hit[k] = evt_vec[k-NUM_FIXED][sel[k-NUM_FIXED]];
        end

        logic inc;
        assign inc = count_en & hit[k];

        // A flush restarts the counter from this cycle's event so nothing is dropped.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                count[k] <= '0;
            else if (clear_all)
                count[k] <= '0;
            else if (flush[k])
                count[k] <= CNT_W'(inc);
            else if (inc)
                count[k] <= count[k] + CNT_W'(1);
        end
    end
endmodule

// File: rtl/cpmc_accum_engine.sv
module cpmc_accum_engine
    import cpmc_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 64,
    parameter int PER_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [63:0]       cfg_wdata,
    input  logic              cmd_init,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cyc_tick,
    input  logic              inst_tick,
    input  logic [127:0]      evt_a_vec,
    input  logic [127:0]      evt_b_vec,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CNT_W-1:0]  mem_wdata,
    input  logic              mem_rvalid,
    input  logic [CNT_W-1:0]  mem_rdata
);
    localparam int CFG_DW = 64;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CTR - 1);

    seq_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [CNT_W-1:0] rdata_q;

    logic [NUM_SEL-1:0][SEL_W-1:0] sel_act;
    logic [PER_W-1:0]  period;
    logic [ADDR_W-1:0] core_base, thread_off;
    logic              relatch, tmr_load, tmr_run, tmr_expire;
    logic              abort, running;
    logic [NUM_CTR-1:0] flush;
    logic [NUM_CTR-1:0][CNT_W-1:0] count;
    logic [NUM_SEL-1:0][EVT_N-1:0] evt_vec;

    assign evt_vec = {evt_b_vec, evt_a_vec};
    assign abort   = cmd_init | cmd_stop;

    cpmc_cfg_regs #(.ADDR_W(ADDR_W), .PER_W(PER_W), .CFG_DW(CFG_DW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_addr    (cfg_addr),
        .wr_data    (cfg_wdata),
        .relatch    (relatch),
        .sel_act    (sel_act),
        .period     (period),
        .core_base  (core_base),
        .thread_off (thread_off)
    );

    cpmc_sample_timer #(.PER_W(PER_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cmd_init),
        .load     (tmr_load),
        .load_val (period),
        .run      (tmr_run),
        .expire   (tmr_expire)
    );

    cpmc_counter_bank #(.CNT_W(CNT_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (cmd_init),
        .count_en  (running),
        .cyc_tick  (cyc_tick),
        .inst_tick (inst_tick),
        .evt_vec   (evt_vec),
        .sel       (sel_act),
        .flush     (flush),
        .count     (count)
    );

    // State register and read-data capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (state_q == ST_RWAIT && mem_rvalid)
                rdata_q <= mem_rdata;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start && period != '0)
                    state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (tmr_expire) begin
                    state_d = ST_RD;
                    idx_d   = '0;
                end
            end
            ST_RD: begin
                state_d = ST_RWAIT;
            end
            ST_RWAIT: begin
                if (mem_rvalid)
                    state_d = ST_WR;
            end
            ST_WR: begin
                if (idx_q == LAST_IDX) begin
                    state_d = (period != '0) ? ST_WAIT : ST_IDLE;
                    idx_d   = '0;
                end else begin
                    state_d = ST_RD;
                    idx_d   = idx_q + IDX_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort) begin
            state_d = ST_IDLE;
            idx_d   = '0;
        end
    end

    // Outputs and internal controls.
    always_comb begin
        running   = (state_q != ST_IDLE);
        tmr_run   = (state_q == ST_WAIT);
        tmr_load  = (state_d == ST_WAIT) && (state_q != ST_WAIT);
        relatch   = tmr_load;
        mem_req   = !abort && ((state_q == ST_RD) || (state_q == ST_WR));
        mem_we    = mem_req && (state_q == ST_WR);
        mem_addr  = core_base + thread_off + (ADDR_W'(idx_q) << 3);
        mem_wdata = rdata_q + count[idx_q];
        flush     = (mem_we) ? (NUM_CTR'(1) << idx_q) : '0;
    end
endmodule

// File: rtl/cpmc_accum_chk.sv
module cpmc_accum_chk #(
    parameter int ADDR_W = 64,
    parameter int PER_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_init,
    input logic              cmd_stop,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] base_q,
    input logic [ADDR_W-1:0] off_q,
    input logic [PER_W-1:0]  period_q,
    input logic              running
);
    logic [ADDR_W-1:0] rd_addr_q;
    logic              rd_seen_q;
    logic [ADDR_W-1:0] rel;

    assign rel = mem_addr - base_q - off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_addr_q <= '0;
            rd_seen_q <= 1'b0;
        end else if (mem_req && !mem_we) begin
            rd_addr_q <= mem_addr;
            rd_seen_q <= 1'b1;
        end
    end

    // R8
    init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_init |=> !mem_req);

    // R7
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> !mem_req);

    // R4
    rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (rd_seen_q && mem_addr == rd_addr_q));

    // R4
    rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (rel[2:0] == 3'd0 && rel < ADDR_W'(32)));

    // R6
    zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && period_q == '0) |=> !running);
endmodule

bind cpmc_accum_engine cpmc_accum_chk #(.ADDR_W(ADDR_W), .PER_W(PER_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_init (cmd_init),
    .cmd_stop (cmd_stop),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .base_q   (core_base),
    .off_q    (thread_off),
    .period_q (period),
    .running  (running)
);

// File: tb/cpmc_accum_engine_test.sv
module cpmc_accum_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] BASE = 64'h0000_0040_0000_0000;
    localparam logic [63:0] OFF  = 64'h0000_0000_0000_0A40;

    typedef struct packed {
        logic [6:0]  sel_a;
        logic [6:0]  sel_b;
        logic [6:0]  bit_a;
        logic [6:0]  bit_b;
        logic [15:0] per;
        logic [15:0] ncyc;
        logic [7:0]  div;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{7'd5,   7'd100, 7'd5,   7'd100, 16'd20, 16'd37,  8'd1},
        '{7'd0,   7'd127, 7'd1,   7'd127, 16'd9,  16'd50,  8'd2},
        '{7'd64,  7'd3,   7'd64,  7'd4,   16'd5,  16'd100, 8'd3},
        '{7'd127, 7'd0,   7'd127, 7'd0,   16'd1,  16'd40,  8'd5},
        '{7'd33,  7'd33,  7'd33,  7'd32,  16'd64, 16'd10,  8'd4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic cmd_init = 1'b0, cmd_start = 1'b0, cmd_stop = 1'b0;
    logic cyc_tick = 1'b0, inst_tick = 1'b0;
    logic [127:0] evt_a_vec = '0, evt_b_vec = '0;
    logic mem_req, mem_we;
    logic [63:0] mem_addr, mem_wdata;
    logic mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    logic [63:0] mem [4];
    logic [63:0] seed_val [4];
    logic seed_go = 1'b0, log_clr = 1'b0;
    logic [63:0] log_addr [16];
    logic log_we [16];
    int log_cyc [16];
    int log_n = 0, cyc_cnt = 0, bad_cnt = 0;
    logic [63:0] rel;
    int widx;

    int total = 0, fails = 0;
    int n;
    vec_t t;
    logic [63:0] exp_w [4];
    logic [63:0] snap;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpmc_accum_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cmd_init(cmd_init), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cyc_tick(cyc_tick), .inst_tick(inst_tick), .evt_a_vec(evt_a_vec), .evt_b_vec(evt_b_vec),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // Memory model: one-edge read latency, request log with edge numbers.
    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        mem_rvalid <= 1'b0;
        if (seed_go)
            for (int k = 0; k < 4; k++) mem[k] <= seed_val[k];
        if (log_clr)
            log_n <= 0;
        else if (mem_req && log_n < 16) begin
            log_addr[log_n] <= mem_addr;
            log_we[log_n]   <= mem_we;
            log_cyc[log_n]  <= cyc_cnt;
            log_n           <= log_n + 1;
        end
        if (mem_req) begin
            rel = mem_addr - BASE - OFF;
            if (rel[2:0] != 3'd0 || rel >= 64'd32)
                bad_cnt <= bad_cnt + 1;
            else begin
                widx = int'(rel >> 3);
                if (mem_we)
                    mem[widx] <= mem_wdata;
                else begin
                    mem_rdata  <= mem[widx];
                    mem_rvalid <= 1'b1;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic do_init();
        @(negedge clk); cmd_init = 1'b1;
        @(negedge clk); cmd_init = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk); cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); cmd_stop = 1'b1;
        @(negedge clk); cmd_stop = 1'b0;
    endtask

    task automatic clear_log();
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
    endtask

    task automatic seed_mem(input logic [63:0] s0, input logic [63:0] s1,
                            input logic [63:0] s2, input logic [63:0] s3);
        @(negedge clk);
        seed_val[0] = s0; seed_val[1] = s1; seed_val[2] = s2; seed_val[3] = s3;
        seed_go = 1'b1;
        @(negedge clk); seed_go = 1'b0;
    endtask

    task automatic run_ev(input int k, input int ba, input bit ea, input int bb, input bit eb, input int div);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            cyc_tick  = 1'b1;
            inst_tick = (i % div == 0);
            evt_a_vec = ea ? (128'd1 << ba) : '0;
            evt_b_vec = eb ? (128'd1 << bb) : '0;
        end
        @(negedge clk);
        cyc_tick = 1'b0; inst_tick = 1'b0; evt_a_vec = '0; evt_b_vec = '0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R10: reset state
        wait_cyc(3);
        chk("R10 req during reset", mem_req, 0);
        rst_n = 1'b1;
        wait_cyc(3);
        chk("R10 req after reset", mem_req, 0);

        cfg_write(3'd3, BASE);
        cfg_write(3'd4, OFF);

        // Table-driven accumulation: R1, R2, R5
        for (int v = 0; v < 5; v++) begin
            t = VECS[v];
            seed_mem(64'h0000_0001_FFFF_FFF0 + 64'(v), 64'h10 * 64'(v + 1), 64'h0, 64'hFFFF_FFFF);
            cfg_write(3'd0, 64'(t.sel_a));
            cfg_write(3'd1, 64'(t.sel_b));
            cfg_write(3'd2, 64'(t.per));
            do_init();
            do_start();
            run_ev(int'(t.ncyc), int'(t.bit_a), 1'b1, int'(t.bit_b), 1'b1, int'(t.div));
            wait_cyc(2 * int'(t.per) + 60);
            do_stop();
            wait_cyc(4);
            exp_w[0] = seed_val[0] + 64'(t.ncyc);
            exp_w[1] = seed_val[1] + 64'((int'(t.ncyc) - 1) / int'(t.div) + 1);
            exp_w[2] = seed_val[2] + ((t.bit_a == t.sel_a) ? 64'(t.ncyc) : 64'd0);
            exp_w[3] = seed_val[3] + ((t.bit_b == t.sel_b) ? 64'(t.ncyc) : 64'd0);
            chk("R1 R5 cycle word", mem[0], exp_w[0]);
            chk("R1 R5 instr word", mem[1], exp_w[1]);
            chk("R2 R5 select A word", mem[2], exp_w[2]);
            chk("R2 R5 select B word", mem[3], exp_w[3]);
        end

        // R3 timing and R4 request order
        do_init();
        cfg_write(3'd2, 64'd7);
        clear_log();
        do_start();
        n = 1;
        while (!mem_req && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk("R3 first read delay", 64'(n), 64'd8);
        wait_cyc(40);
        for (int i = 0; i < 8; i++) begin
            chk("R4 request address", log_addr[i], BASE + OFF + 64'(8 * (i / 2)));
            chk("R4 request kind", 64'(log_we[i]), 64'(i % 2));
        end
        chk("R3 second sample spacing", 64'(log_cyc[8] - log_cyc[7]), 64'd8);
        do_stop();

        // R7: no requests after stop
        clear_log();
        wait_cyc(60);
        chk("R7 quiet after stop", 64'(log_n), 64'd0);

        // R6: zero period
        do_init();
        cfg_write(3'd2, 64'd0);
        clear_log();
        do_start();
        wait_cyc(100);
        chk("R6 zero period no requests", 64'(log_n), 64'd0);

        // R9: select change applies from next period
        seed_mem(64'd0, 64'd0, 64'd500, 64'd0);
        cfg_write(3'd0, 64'd10);
        cfg_write(3'd2, 64'd40);
        do_init();
        do_start();
        cfg_write(3'd0, 64'd20);
        run_ev(10, 10, 1'b1, 0, 1'b0, 1);
        wait_cyc(80);
        run_ev(10, 10, 1'b1, 0, 1'b0, 1);
        run_ev(5, 20, 1'b1, 0, 1'b0, 1);
        wait_cyc(100);
        do_stop();
        wait_cyc(4);
        chk("R9 deferred select", mem[2], 64'd515);

        // R7: events while stopped not counted
        snap = mem[0];
        run_ev(30, 0, 1'b0, 0, 1'b0, 1);
        cfg_write(3'd2, 64'd10);
        do_start();
        wait_cyc(50);
        do_stop();
        wait_cyc(4);
        chk("R7 idle events ignored", mem[0], snap);

        // R8: init clears live counters
        cfg_write(3'd2, 64'd200);
        do_start();
        run_ev(20, 0, 1'b0, 0, 1'b0, 1);
        do_stop();
        snap = mem[0];
        do_init();
        cfg_write(3'd2, 64'd10);
        do_start();
        wait_cyc(50);
        do_stop();
        wait_cyc(4);
        chk("R8 init clears counters", mem[0], snap);

        chk("R4 no stray addresses", 64'(bad_cnt), 64'd0);

        summary();
        $finish;
    end
endmodule